// File: doc/BRIEF.md
# TPM Locality Claim Sequencer

This block carries out the power-on handshake with a TPM over a generic register-access master. After a start pulse it reads the identity word and inspects the access register. If locality zero is already held, it releases it first. It then asks for locality zero, confirms the grant and checks the interface-family field of the status register. Last, it reads the revision byte. Each access goes out as one request (read or write, byte offset, byte count, write data). The master answers every request with a one-cycle completion strobe, which carries the read data.

The request side is a valid/ready channel. Once `req_valid` is high, the address, direction, length and write data stay constant until the cycle in which `req_ready` is also high. The master may hold `req_ready` low for any number of cycles. The completion side has no back-pressure, because the sequencer always waits for it. When the sequence ends, `done` rises together with either `pass` or a non-zero `fail_code`. The vendor ID, device ID and revision are presented alongside. All results hold until the next accepted start.

Top module: `tpm_locality_seq`

## Requirements
- R1: After reset `busy`, `done`, `pass`, `req_valid`, `fail_code`, `vendor_id`, `device_id` and `revision` are all zero.
- R2: A start pulse while idle begins a sequence: one cycle later `busy` is 1, and `done`, `pass`, `fail_code`, `vendor_id`, `device_id` and `revision` are cleared. A start pulse while `busy` is 1 has no effect.
- R3: Only one access is in flight at a time. `req_valid` stays low from an accepted request until its `rsp_done`. While `req_valid` is high and `req_ready` is low, the request fields do not change.
- R4: The first access reads 4 bytes at offset 0xF00. `vendor_id` takes `rsp_rdata[15:0]` and `device_id` takes `rsp_rdata[31:16]`.
- R5: The second access reads 1 byte at offset 0x000 (access register). If bit 5 (active locality) of that byte is 1, the sequencer writes 1 byte 0x20 to offset 0x000 and then reads the access register again.
- R6: The last access-register value read before the claim is checked with bit 0 (establishment) cleared. If it is not exactly 0x80, the sequence ends with `fail_code` = 1.
- R7: The claim writes 1 byte 0x02 to offset 0x000 and then reads the access register back. If that value, with bit 0 cleared, is not 0xA0, the sequence ends with `fail_code` = 2.
- R8: After the grant, 4 bytes are read at offset 0x018. If bits 27:26 of that word are not 01, the sequence ends with `fail_code` = 3.
- R9: After a good family check, 1 byte is read at offset 0xF04. `revision` takes `rsp_rdata[7:0]`, `pass` is 1 and `fail_code` is 0. A failed sequence issues no further access and leaves `revision` at 0.
- R10: Once `done` is 1, `done`, `pass`, `fail_code`, `vendor_id`, `device_id` and `revision` stay unchanged and `busy` stays 0 until the next accepted start.
- R11: Bit 0 of the access register never affects either the pre-claim check or the grant check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, results valid |
| pass | output | 1 | All checks succeeded |
| fail_code | output | 2 | 0 none, 1 pre-claim access value, 2 grant refused, 3 wrong family |
| vendor_id | output | 16 | Low half of the identity word |
| device_id | output | 16 | High half of the identity word |
| revision | output | 8 | Revision byte |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Master accepts request |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | ADDR_W | Register byte offset |
| req_len | output | LEN_W | Byte count of the access |
| req_wdata | output | DATA_W | Write data, low byte first |
| rsp_done | input | 1 | One-cycle completion of the accepted request |
| rsp_rdata | input | DATA_W | Read data, valid with rsp_done |

## Verification
A step register that is wrong or skips a step shows up on the very next request. The bench compares each accepted request against its expected list, so an access with the wrong offset, direction, length or data, or one out of order, is reported on its handshake cycle. A wrong verdict on an access byte or the family field appears either as an extra or missing request right after the completion that was misjudged, or as a wrong `fail_code`/`pass` in the cycle after that completion. A result register that is not held shows as a change on an idle cycle.

// File: rtl/tpm_seq_pkg.sv
package tpm_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ISSUE,
    PH_WAIT
  } phase_t;

  typedef enum logic [2:0] {
    SP_IDENT,
    SP_ACC_FIRST,
    SP_RELEASE,
    SP_ACC_RECHK,
    SP_CLAIM,
    SP_GRANT,
    SP_FAMILY,
    SP_REVISION
  } step_t;

  typedef enum logic [1:0] {
    FC_NONE     = 2'd0,
    FC_PRECLAIM = 2'd1,
    FC_GRANT    = 2'd2,
    FC_FAMILY   = 2'd3
  } fail_t;

  typedef struct packed {
    logic  finish;
    fail_t code;
    step_t next;
  } verdict_t;

  // register byte offsets
  localparam int OFS_ACCESS = 'h000;
  localparam int OFS_STATUS = 'h018;
  localparam int OFS_IDENT  = 'hF00;
  localparam int OFS_REV    = 'hF04;

  // access register bit meanings
  localparam int ACC_VALID_BIT  = 7;
  localparam int ACC_ACTIVE_BIT = 5;
  localparam int ACC_REQ_BIT    = 1;
  localparam int ACC_ESTAB_BIT  = 0;

  localparam logic [7:0] ACC_IDLE_OK  = 8'(1 << ACC_VALID_BIT);
  localparam logic [7:0] ACC_GRANT_OK = 8'((1 << ACC_VALID_BIT) | (1 << ACC_ACTIVE_BIT));
  localparam logic [7:0] ACC_RELEASE  = 8'(1 << ACC_ACTIVE_BIT);
  localparam logic [7:0] ACC_REQUEST  = 8'(1 << ACC_REQ_BIT);
  localparam logic [7:0] ACC_MASK     = ~8'(1 << ACC_ESTAB_BIT);

  // status register family field
  localparam int         FAM_LSB = 26;
  localparam logic [1:0] FAM_OK  = 2'b01;

endpackage

// File: rtl/tpm_req_decode.sv
module tpm_req_decode
  import tpm_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3
) (
  input  step_t              step,
  output logic               wr,
  output logic [ADDR_W-1:0]  addr,
  output logic [LEN_W-1:0]   len,
  output logic [DATA_W-1:0]  wdata
);
  localparam logic [LEN_W-1:0] LEN_BYTE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_WORD = LEN_W'(4);

  always_comb begin
    wr    = 1'b0;
    addr  = ADDR_W'(OFS_ACCESS);
    len   = LEN_BYTE;
    wdata = '0;
    unique case (step)
      SP_IDENT: begin
        addr = ADDR_W'(OFS_IDENT);
        len  = LEN_WORD;
      end
      SP_ACC_FIRST, SP_ACC_RECHK, SP_GRANT: begin
        addr = ADDR_W'(OFS_ACCESS);
      end
      SP_RELEASE: begin
        wr    = 1'b1;
        wdata = DATA_W'(ACC_RELEASE);
      end
      SP_CLAIM: begin
        wr    = 1'b1;
        wdata = DATA_W'(ACC_REQUEST);
      end
      SP_FAMILY: begin
        addr = ADDR_W'(OFS_STATUS);
        len  = LEN_WORD;
      end
      SP_REVISION: begin
        addr = ADDR_W'(OFS_REV);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tpm_resp_eval.sv
module tpm_resp_eval
  import tpm_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  step_t             step,
  input  logic [DATA_W-1:0] rdata,
  output verdict_t          verdict
);
  logic [7:0] acc_byte;
  logic [7:0] acc_masked;
  logic [1:0] family;

  assign acc_byte   = rdata[7:0];
  assign acc_masked = acc_byte & ACC_MASK;
  assign family     = rdata[FAM_LSB +: 2];

  always_comb begin
    verdict.finish = 1'b0;
    verdict.code   = FC_NONE;
    verdict.next   = step;
    unique case (step)
      SP_IDENT:     verdict.next = SP_ACC_FIRST;
      SP_ACC_FIRST: begin
        if (acc_byte[ACC_ACTIVE_BIT]) begin
          verdict.next = SP_RELEASE;
        end else if (acc_masked == ACC_IDLE_OK) begin
          verdict.next = SP_CLAIM;
        end else begin
          verdict.finish = 1'b1;
          verdict.code   = FC_PRECLAIM;
        end
      end
      SP_RELEASE:   verdict.next = SP_ACC_RECHK;
      SP_ACC_RECHK: begin
        if (acc_masked == ACC_IDLE_OK) begin
          verdict.next = SP_CLAIM;
        end else begin
          verdict.finish = 1'b1;
          verdict.code   = FC_PRECLAIM;
        end
      end
      SP_CLAIM:     verdict.next = SP_GRANT;
      SP_GRANT: begin
        if (acc_masked == ACC_GRANT_OK) begin
          verdict.next = SP_FAMILY;
        end else begin
          verdict.finish = 1'b1;
          verdict.code   = FC_GRANT;
        end
      end
      SP_FAMILY: begin
        if (family == FAM_OK) begin
          verdict.next = SP_REVISION;
        end else begin
          verdict.finish = 1'b1;
          verdict.code   = FC_FAMILY;
        end
      end
      SP_REVISION:  verdict.finish = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/tpm_seq_fsm.sv
module tpm_seq_fsm
  import tpm_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     req_ready,
  input  logic     rsp_done,
  input  verdict_t verdict,
  output step_t    step,
  output logic     req_valid,
  output logic     busy,
  output logic     launch,
  output logic     resp_take,
  output logic     finish
);
  phase_t phase;

  assign req_valid = (phase == PH_ISSUE);
  assign busy      = (phase != PH_IDLE);
  assign launch    = (phase == PH_IDLE) && start;
  assign resp_take = (phase == PH_WAIT) && rsp_done;
  assign finish    = resp_take && verdict.finish;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      step  <= SP_IDENT;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_ISSUE;
            step  <= SP_IDENT;
          end
        end
        PH_ISSUE: begin
          if (req_ready) phase <= PH_WAIT;
        end
        PH_WAIT: begin
          if (rsp_done) begin
            if (verdict.finish) begin
              phase <= PH_IDLE;
            end else begin
              phase <= PH_ISSUE;
              step  <= verdict.next;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tpm_result_regs.sv
module tpm_result_regs
  import tpm_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              resp_take,
  input  logic              finish,
  input  step_t             step,
  input  fail_t             code,
  input  logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              pass,
  output logic [1:0]        fail_code,
  output logic [15:0]       vendor_id,
  output logic [15:0]       device_id,
  output logic [7:0]        revision
);
  always_ff @(posedge clk) begin
    if (!rst_n || launch) begin
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_code <= 2'd0;
      vendor_id <= '0;
      device_id <= '0;
      revision  <= '0;
    end else begin
      if (resp_take && step == SP_IDENT) begin
        vendor_id <= rdata[15:0];
        device_id <= rdata[31:16];
      end
      if (finish) begin
        done      <= 1'b1;
        pass      <= (code == FC_NONE);
        fail_code <= code;
        if (code == FC_NONE) revision <= rdata[7:0];
      end
    end
  end
endmodule

// File: rtl/tpm_locality_seq.sv
module tpm_locality_seq
  import tpm_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [1:0]        fail_code,
  output logic [15:0]       vendor_id,
  output logic [15:0]       device_id,
  output logic [7:0]        revision,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_done,
  input  logic [DATA_W-1:0] rsp_rdata
);
  step_t    step;
  verdict_t verdict;
  logic     launch;
  logic     resp_take;
  logic     finish;

  tpm_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .verdict   (verdict),
    .step      (step),
    .req_valid (req_valid),
    .busy      (busy),
    .launch    (launch),
    .resp_take (resp_take),
    .finish    (finish)
  );

  tpm_req_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_dec (
    .step  (step),
    .wr    (req_write),
    .addr  (req_addr),
    .len   (req_len),
    .wdata (req_wdata)
  );

  tpm_resp_eval #(.DATA_W(DATA_W)) u_eval (
    .step    (step),
    .rdata   (rsp_rdata),
    .verdict (verdict)
  );

  tpm_result_regs #(.DATA_W(DATA_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .resp_take (resp_take),
    .finish    (finish),
    .step      (step),
    .code      (verdict.code),
    .rdata     (rsp_rdata),
    .done      (done),
    .pass      (pass),
    .fail_code (fail_code),
    .vendor_id (vendor_id),
    .device_id (device_id),
    .revision  (revision)
  );
endmodule

// File: rtl/tpm_locality_seq_chk.sv
module tpm_locality_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [1:0]        fail_code,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_done
);
  logic in_flight;

  always_ff @(posedge clk) begin
    if (!rst_n)                     in_flight <= 1'b0;
    else if (req_valid && req_ready) in_flight <= 1'b1;
    else if (rsp_done)              in_flight <= 1'b0;
  end

  // R3
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !req_valid);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_write) && $stable(req_addr)
                                   && $stable(req_len) && $stable(req_wdata)));

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !pass));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !busy && $stable(pass) && $stable(fail_code)));

  // R9
  pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && fail_code == 2'd0));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind tpm_locality_seq tpm_locality_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
) chk_i (.*);

// File: tb/tpm_locality_seq_test.sv
module tpm_locality_seq_test;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, pass;
  logic [1:0] fail_code;
  logic [15:0] vendor_id, device_id;
  logic [7:0] revision;
  logic req_valid, req_write;
  logic req_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0] req_len;
  logic [DATA_W-1:0] req_wdata;
  logic rsp_done = 1'b0;
  logic [DATA_W-1:0] rsp_rdata = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  tpm_locality_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) uut (.*);

  // responder model state
  logic [31:0] m_ident, m_status;
  logic [7:0]  m_acc, m_rel, m_claim, m_rev;
  logic [3:0]  tick = '0;
  logic        pending = 1'b0;
  logic [1:0]  lat = '0;
  logic [31:0] rval = '0;

  always @(posedge clk) begin
    tick      <= tick + 4'd1;
    req_ready <= (tick[1:0] != 2'b01);
    rsp_done  <= 1'b0;
    if (pending) begin
      if (lat == 2'd0) begin
        rsp_done  <= 1'b1;
        rsp_rdata <= rval;
        pending   <= 1'b0;
      end else begin
        lat <= lat - 2'd1;
      end
    end
    if (req_valid && req_ready) begin
      pending <= 1'b1;
      lat     <= tick[2:1];
      rval    <= '0;
      if (req_write) begin
        if (req_addr == 24'h000 && req_wdata[5]) m_acc <= m_rel;
        if (req_addr == 24'h000 && req_wdata[1]) m_acc <= m_claim;
      end else begin
        case (req_addr)
          24'hF00: rval <= m_ident;
          24'h000: rval <= {24'h0, m_acc};
          24'h018: rval <= m_status;
          24'hF04: rval <= {24'h0, m_rev};
          default: rval <= 32'hDEAD_BEEF;
        endcase
      end
    end
  end

  // scoreboard
  typedef struct packed {
    logic        wr;
    logic [23:0] addr;
    logic [2:0]  len;
    logic [31:0] wd;
  } item_t;
  item_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic wr, input logic [23:0] a, input logic [2:0] l,
                      input logic [31:0] d);
    item_t it;
    it.wr = wr; it.addr = a; it.len = l; it.wd = d;
    exp_q.push_back(it);
  endtask

  // monitor: compares each accepted request with the next expected one (R3..R9)
  always @(negedge clk) begin
    cycles++;
    if (rst_n && req_valid && req_ready) begin
      item_t act;
      act.wr = req_write; act.addr = req_addr; act.len = req_len;
      act.wd = req_write ? req_wdata : 32'h0;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected request", {act.addr, 5'd0, act.wr, act.len[1:0]}, 32'h0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(act == e, "R5", "request addr/dir/len",
              {act.addr, act.len, act.wr, 4'h0}, {e.addr, e.len, e.wr, 4'h0});
        check(act.wd == e.wd, "R7", "request wdata", act.wd, e.wd);
      end
    end
  end

  // driver: computes expected accesses and results from the requirements
  task automatic run(input logic [31:0] ident, input logic [7:0] acc0, input logic [7:0] rel,
                     input logic [7:0] claim, input logic [31:0] sts, input logic [7:0] rev,
                     input bit poke_busy);
    logic [7:0] pre;
    logic [1:0] exp_code;
    bit ok;
    m_ident = ident; m_acc = acc0; m_rel = rel; m_claim = claim; m_status = sts; m_rev = rev;
    exp_code = 2'd0;
    push(1'b0, 24'hF00, 3'd4, 32'h0);               // R4
    push(1'b0, 24'h000, 3'd1, 32'h0);               // R5
    pre = acc0;
    if (acc0[5]) begin
      push(1'b1, 24'h000, 3'd1, 32'h20);            // R5 release
      push(1'b0, 24'h000, 3'd1, 32'h0);
      pre = rel;
    end
    if ((pre & 8'hFE) != 8'h80) exp_code = 2'd1;    // R6, R11
    else begin
      push(1'b1, 24'h000, 3'd1, 32'h02);            // R7
      push(1'b0, 24'h000, 3'd1, 32'h0);
      if ((claim & 8'hFE) != 8'hA0) exp_code = 2'd2;
      else begin
        push(1'b0, 24'h018, 3'd4, 32'h0);           // R8
        if (sts[27:26] != 2'b01) exp_code = 2'd3;
        else push(1'b0, 24'hF04, 3'd1, 32'h0);      // R9
      end
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy && !done && !pass && fail_code == 0 && vendor_id == 0 && revision == 0,
          "R2", "cleared and busy after start", {busy, done, pass, fail_code}, 5'b10000);
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;                  // R2: ignored while busy
    end
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    check(done && !busy, "R10", "sequence completes", {done, busy}, 2'b10);
    check(exp_q.size() == 0, "R3", "all expected requests seen", exp_q.size(), 0);
    exp_q.delete();
    check(fail_code == exp_code, "R6", "fail_code", fail_code, exp_code);
    check(pass == (exp_code == 0), "R9", "pass", pass, exp_code == 0);
    check(vendor_id == ident[15:0] && device_id == ident[31:16], "R4", "identity",
          {device_id, vendor_id}, ident);
    check(revision == ((exp_code == 0) ? rev : 8'h00), "R9", "revision", revision,
          (exp_code == 0) ? rev : 8'h00);
    begin
      logic [43:0] snap;
      snap = {done, pass, fail_code, vendor_id, device_id, revision};
      ok = 1'b1;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if ({done, pass, fail_code, vendor_id, device_id, revision} != snap || busy || req_valid)
          ok = 1'b0;
      end
      check(ok, "R10", "results held while idle", {31'h0, ok}, 32'h1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !pass && !req_valid && fail_code == 0 &&
          vendor_id == 0 && device_id == 0 && revision == 0,
          "R1", "reset state", {busy, done, pass, req_valid, fail_code}, 6'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9, R11: normal claim, establishment bit set in both reads
    run(32'h1B2C_15D1, 8'h81, 8'h80, 8'hA1, 32'h0400_2090, 8'h16, 1'b0);
    // R5: locality already active, release then claim; second start ignored (R2)
    run(32'h0042_ABCD, 8'hA1, 8'h80, 8'hA0, 32'h0400_0080, 8'h3C, 1'b1);
    // R6: invalid access value before claim
    run(32'h1111_2222, 8'hC0, 8'h80, 8'hA0, 32'h0400_0000, 8'h01, 1'b0);
    // R6: release does not clear active locality
    run(32'h3333_4444, 8'hA0, 8'hA0, 8'hA0, 32'h0400_0000, 8'h02, 1'b0);
    // R7: grant refused
    run(32'h5555_6666, 8'h80, 8'h80, 8'h81, 32'h0400_0000, 8'h03, 1'b0);
    // R8: wrong family field
    run(32'h7777_8888, 8'h80, 8'h80, 8'hA0, 32'h0800_0090, 8'h04, 1'b0);
    // R8: family field 11 also rejected
    run(32'h9999_AAAA, 8'h81, 8'h80, 8'hA1, 32'h0C00_0000, 8'h05, 1'b0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule